// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is the target side of a two-wire serial bus for a peripheral that holds an internal register file. It runs on a system clock that is much faster than the bus clock. It samples the serial clock and data lines through synchronizers, finds START and STOP conditions and clock edges, and drives only an output enable for the open-drain data line. Its 7-bit bus address is built at run time from two bits fixed high, four configuration bits and one strap pin, so up to 32 copies can share one bus.

A master writes registers by sending the device address with the write direction, then a one-byte register pointer, then any number of data bytes. It reads registers with two transfers. First it sends a write that carries only the pointer. Then it sends a repeated START and the address with the read direction, and clocks out bytes until it answers one with a NACK. The pointer advances by one after every byte that is written or read, so a burst covers consecutive registers. The block also answers the general call address and hands the byte that follows it to a command output.

The register port is simple: a pointer, write data with a one-cycle write strobe, and a one-cycle read strobe. Read data must be valid combinationally in the cycle the read strobe is high.

Top module: `i2c_reg_slave`

## Requirements
- R1: The device address, MSB first, is 1, 1, cfg_bits[3], cfg_bits[2], cfg_bits[1], cfg_bits[0], strap_pin. A first byte whose upper seven bits equal it is acknowledged by driving SDA low during the 9th clock. Bit 0 of that byte is the direction: 0 means write and 1 means read.
- R2: A first byte that matches neither the device address nor the general call is not acknowledged. SDA stays released, and every later byte is ignored and not acknowledged until the next START or STOP.
- R3: In a write transfer, the first byte after the address loads the register pointer. Each later byte gives exactly one reg_we pulse, with reg_addr equal to the pointer and reg_wdata equal to the byte. Every one of these bytes is acknowledged.
- R4: The pointer increments by one after each data byte that is written or read, and wraps from 8'hFF to 8'h00.
- R5: In a read transfer, each byte is taken from reg_rdata at the current pointer, with one reg_re pulse per byte. It is shifted out MSB first on SDA.
- R6: After each read byte the block samples the master's acknowledge. An ACK (SDA low) starts the next byte. A NACK (SDA high) ends the transfer: SDA stays released and there is no further reg_re.
- R7: The general call byte 8'h00 (address 0, write) is acknowledged. The next byte appears on gc_cmd with a one-cycle gc_valid pulse and is acknowledged; later bytes are ignored. The byte 8'h01 (general call with read) is not acknowledged.
- R8: A START or repeated START, even in the middle of a byte, releases SDA and makes the next byte an address byte. A STOP releases SDA and returns the block to idle.
- R9: A START followed directly by a STOP makes no register access and no general-call delivery, and a normal transfer afterwards works.
- R10: sda_oe changes only while the synchronized SCL is low, after its falling edge has been seen.
- R11: reg_we, reg_re and gc_valid are each single-cycle pulses. reg_we and reg_re are never high together.
- R12: While rst is high and in the first cycle after it, sda_oe, reg_we, reg_re and gc_valid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad (asynchronous) |
| sda_in | input | 1 | Bus data line as seen at the pad (asynchronous) |
| cfg_bits | input | 4 | Programmable address bits 4..1 |
| strap_pin | input | 1 | Hardwired address bit 0 |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Write data for the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data at reg_addr, combinational |
| reg_re | output | 1 | One-cycle strobe when a read byte is taken |
| gc_cmd | output | 8 | Byte that follows a general call |
| gc_valid | output | 1 | One-cycle strobe for gc_cmd |

## Verification
The bench goes after the pointer: it checks that a pointer-only write followed by a repeated START reads from that pointer, and that bursts wrap at 8'hFF. A design that reset or failed to advance the pointer would return the wrong bytes. It also aborts a byte halfway with a repeated START, sends an empty START/STOP pair, and changes the strap pin between transfers. A state machine that did not resynchronize on START would take the next byte as a pointer, and one that decoded the address wrongly would acknowledge the old address. Finally it NACKs the last read byte and sends bytes after a mismatched address and after a general call. A slave that kept SDA driven there would corrupt the STOP, and one that kept decoding would issue stray strobes.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

    localparam int              BYTE_W   = 8;
    localparam int              CNT_W    = 4;
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W);
    localparam logic [1:0]      ADDR_FIXED = 2'b11;
    localparam logic [6:0]      GCALL_ADDR = 7'h00;

    typedef logic [BYTE_W-1:0] byte_t;

    // Engine states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } eng_state_t;

    // Meaning of the byte currently being received
    typedef enum logic [2:0] {
        RX_ADDR,
        RX_PTR,
        RX_DATA,
        RX_GCMD,
        RX_NONE
    } rx_role_t;

    // Bus events found by the line synchronizer
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    function automatic logic [6:0] own_addr(input logic [3:0] cfg, input logic strap);
        return {ADDR_FIXED, cfg, strap};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_reg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output logic     scl_lvl,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        scl_lvl      = scl_s;
        evt.scl_rise = scl_s & ~scl_d;
        evt.scl_fall = ~scl_s & scl_d;
        // data edges while the clock stays high mark bus conditions
        evt.start    = scl_s & scl_d & sda_d & ~sda_s;
        evt.stop     = scl_s & scl_d & ~sda_d & sda_s;
        evt.sda      = sda_s;
    end

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2c_reg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt,
    input  logic [6:0] my_addr,
    input  byte_t      rd_data,
    output logic       sda_oe,
    output byte_t      ptr,
    output byte_t      wr_data,
    output logic       wr_en,
    output logic       rd_en,
    output byte_t      gc_cmd,
    output logic       gc_valid
);

    eng_state_t       st;
    rx_role_t         role;
    logic [CNT_W-1:0] cnt;
    byte_t            sh;
    logic             rd_mode;
    logic             bump;
    logic             mack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            role     <= RX_ADDR;
            cnt      <= '0;
            sh       <= '0;
            rd_mode  <= 1'b0;
            bump     <= 1'b0;
            mack     <= 1'b0;
            sda_oe   <= 1'b0;
            ptr      <= '0;
            wr_data  <= '0;
            wr_en    <= 1'b0;
            rd_en    <= 1'b0;
            gc_cmd   <= '0;
            gc_valid <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            rd_en    <= 1'b0;
            gc_valid <= 1'b0;
            if (evt.start) begin
                st     <= ST_RX;
                role   <= RX_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (evt.scl_rise && cnt < BIT_LAST) begin
                            sh  <= {sh[BYTE_W-2:0], evt.sda};
                            cnt <= cnt + 1'b1;
                        end else if (evt.scl_fall && cnt == BIT_LAST) begin
                            cnt  <= '0;
                            bump <= 1'b0;
                            case (role)
                                RX_ADDR: begin
                                    if (sh[BYTE_W-1:1] == my_addr) begin
                                        sda_oe  <= 1'b1;
                                        st      <= ST_ACK;
                                        rd_mode <= sh[0];
                                        role    <= RX_PTR;
                                    end else if (sh == {GCALL_ADDR, 1'b0}) begin
                                        sda_oe  <= 1'b1;
                                        st      <= ST_ACK;
                                        rd_mode <= 1'b0;
                                        role    <= RX_GCMD;
                                    end else begin
                                        st <= ST_SKIP;
                                    end
                                end
                                RX_PTR: begin
                                    ptr    <= sh;
                                    sda_oe <= 1'b1;
                                    st     <= ST_ACK;
                                    role   <= RX_DATA;
                                end
                                RX_DATA: begin
                                    wr_data <= sh;
                                    wr_en   <= 1'b1;
                                    bump    <= 1'b1;
                                    sda_oe  <= 1'b1;
                                    st      <= ST_ACK;
                                end
                                RX_GCMD: begin
                                    gc_cmd   <= sh;
                                    gc_valid <= 1'b1;
                                    sda_oe   <= 1'b1;
                                    st       <= ST_ACK;
                                    role     <= RX_NONE;
                                end
                                default: st <= ST_SKIP;
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            bump   <= 1'b0;
                            if (bump) ptr <= ptr + 1'b1;
                            if (rd_mode) begin
                                sh     <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                rd_en  <= 1'b1;
                                cnt    <= '0;
                                st     <= ST_TX;
                            end else if (role == RX_NONE) begin
                                st <= ST_SKIP;
                            end else begin
                                st <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (evt.scl_fall) begin
                            if (cnt == BIT_LAST) begin
                                sda_oe <= 1'b0;
                                st     <= ST_MACK;
                            end else begin
                                sh     <= {sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (evt.scl_rise) begin
                            mack <= ~evt.sda;
                            ptr  <= ptr + 1'b1;
                        end else if (evt.scl_fall) begin
                            if (mack) begin
                                sh     <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                rd_en  <= 1'b1;
                                cnt    <= '0;
                                st     <= ST_TX;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [3:0] cfg_bits,
    input  logic       strap_pin,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata,
    output logic       reg_re,
    output logic [7:0] gc_cmd,
    output logic       gc_valid
);

    bus_evt_t   evt;
    logic       scl_lvl;
    logic       start_det;
    logic       stop_det;
    logic [6:0] dev_addr;

    assign dev_addr  = own_addr(cfg_bits, strap_pin);
    assign start_det = evt.start;
    assign stop_det  = evt.stop;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .scl_lvl (scl_lvl),
        .evt     (evt)
    );

    i2c_byte_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .my_addr  (dev_addr),
        .rd_data  (reg_rdata),
        .sda_oe   (sda_oe),
        .ptr      (reg_addr),
        .wr_data  (reg_wdata),
        .wr_en    (reg_we),
        .rd_en    (reg_re),
        .gc_cmd   (gc_cmd),
        .gc_valid (gc_valid)
    );

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
    input logic clk,
    input logic rst,
    input logic sda_oe,
    input logic reg_we,
    input logic reg_re,
    input logic gc_valid,
    input logic scl_lvl,
    input logic start_det,
    input logic stop_det
);

    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl_lvl) || $past(start_det) || $past(stop_det)));

    assert_we_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    assert_re_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> !reg_re);

    assert_gc_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        gc_valid |=> !gc_valid);

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re));

    assert_start_release_R8: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_oe);

    assert_stop_release_R8: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    assert_reset_idle_R12: assert property (@(posedge clk)
        rst |=> (!sda_oe && !reg_we && !reg_re && !gc_valid));

endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .gc_valid  (gc_valid),
    .scl_lvl   (scl_lvl),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/i2c_reg_slave_bench.sv
module i2c_reg_slave_bench;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [3:0] cfg = 4'b1010;
    logic       strap = 1'b1;
    logic       sda_oe;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [7:0] gc_cmd;
    logic       reg_we;
    logic       reg_re;
    logic       gc_valid;
    logic       sda_line;

    logic [7:0]  dut_mem [256];
    logic [7:0]  ref_mem [256];
    logic [15:0] exp_wr [$];
    logic [7:0]  exp_gc [$];

    int checks = 0;
    int errors = 0;
    int re_count = 0;
    int we_count = 0;
    int r10_bad = 0;
    int r11_bad = 0;
    logic prev_oe = 1'b0;
    logic prev_we = 1'b0;
    logic prev_re = 1'b0;
    logic prev_gc = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = dut_mem[reg_addr];

    i2c_reg_slave u_i2c_reg_slave (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .cfg_bits  (cfg),
        .strap_pin (strap),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .reg_re    (reg_re),
        .gc_cmd    (gc_cmd),
        .gc_valid  (gc_valid)
    );

    task automatic fail(input string req, input logic [31:0] act, input logic [31:0] exp);
        errors++;
        $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) fail(req, act, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Reference model, compared on every clock
    always @(negedge clk) begin
        if (!rst) begin
            if (reg_we) begin
                we_count++;
                checks++;
                if (exp_wr.size() == 0) begin
                    fail("R3 unexpected write", {reg_addr, reg_wdata}, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_wr.pop_front();
                    if ({reg_addr, reg_wdata} !== e) fail("R3/R4 write", {reg_addr, reg_wdata}, e);
                end
                dut_mem[reg_addr] = reg_wdata;
            end
            if (gc_valid) begin
                checks++;
                if (exp_gc.size() == 0) fail("R7 unexpected gc", gc_cmd, 0);
                else begin
                    logic [7:0] g;
                    g = exp_gc.pop_front();
                    if (gc_cmd !== g) fail("R7 gc_cmd", gc_cmd, g);
                end
            end
            if (reg_re) re_count++;
            if (sda_oe != prev_oe && scl_m) r10_bad++;
            if ((reg_we && reg_re) || (reg_we && prev_we) || (reg_re && prev_re) || (gc_valid && prev_gc))
                r11_bad++;
            prev_oe = sda_oe;
            prev_we = reg_we;
            prev_re = reg_re;
            prev_gc = gc_valid;
        end
    end

    initial begin
        repeat (150000) @(negedge clk);
        fail("watchdog", 0, 1);
        finish_run();
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b;
        wait_n(Q);
        scl_m = 1'b1;
        wait_n(2 * Q);
        scl_m = 1'b0;
        wait_n(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wait_n(Q);
        scl_m = 1'b1;
        wait_n(Q);
        sda_m = 1'b0;
        wait_n(Q);
        scl_m = 1'b0;
        wait_n(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wait_n(Q);
        scl_m = 1'b1;
        wait_n(Q);
        sda_m = 1'b1;
        wait_n(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        logic acked;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_m = 1'b1;
        wait_n(Q);
        scl_m = 1'b1;
        wait_n(Q);
        acked = ~sda_line;
        wait_n(Q);
        scl_m = 1'b0;
        wait_n(Q);
        chk(req, acked, exp_ack);
    endtask

    task automatic recv_byte(input logic give_ack, input logic [7:0] exp, input string req);
        logic [7:0] b;
        b = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_n(Q);
            scl_m = 1'b1;
            wait_n(Q);
            b = {b[6:0], sda_line};
            wait_n(Q);
            scl_m = 1'b0;
            wait_n(Q);
        end
        bit_out(~give_ack);
        sda_m = 1'b1;
        chk(req, b, exp);
    endtask

    task automatic expect_wr(input logic [7:0] a, input logic [7:0] d);
        exp_wr.push_back({a, d});
        ref_mem[a] = d;
    endtask

    initial begin
        int re_base;
        int we_base;
        for (int i = 0; i < 256; i++) begin
            ref_mem[i] = 8'(i * 7 + 3);
            dut_mem[i] = 8'(i * 7 + 3);
        end
        wait_n(5);
        rst = 1'b0;
        wait_n(1);
        // R12: idle outputs after reset
        chk("R12 sda_oe", sda_oe, 0);
        chk("R12 reg_we", reg_we, 0);
        chk("R12 reg_re", reg_re, 0);
        chk("R12 gc_valid", gc_valid, 0);
        wait_n(Q);

        // R1/R3: burst write, own address 7'h75 (cfg 1010, strap 1)
        expect_wr(8'h10, 8'hA1);
        expect_wr(8'h11, 8'hB2);
        expect_wr(8'h12, 8'hC3);
        bus_start();
        send_byte(8'hEA, 1'b1, "R1 address ack");
        send_byte(8'h10, 1'b1, "R3 pointer ack");
        send_byte(8'hA1, 1'b1, "R3 data ack");
        send_byte(8'hB2, 1'b1, "R3 data ack");
        send_byte(8'hC3, 1'b1, "R3 data ack");
        bus_stop();
        chk("R4 burst writes drained", exp_wr.size(), 0);

        // R5/R6: pointer write, repeated START, read three bytes
        re_base = re_count;
        bus_start();
        send_byte(8'hEA, 1'b1, "R1 address ack");
        send_byte(8'h11, 1'b1, "R3 pointer ack");
        bus_start();
        send_byte(8'hEB, 1'b1, "R1 read address ack");
        recv_byte(1'b1, ref_mem[8'h11], "R5 read byte 0");
        recv_byte(1'b1, ref_mem[8'h12], "R4 read byte 1");
        recv_byte(1'b0, ref_mem[8'h13], "R6 read byte 2");
        wait_n(Q);
        chk("R6 released after NACK", sda_oe, 0);
        chk("R6 reg_re count", re_count - re_base, 3);
        bus_stop();

        // R2: mismatched address (7'h74 while strap is 1)
        we_base = we_count;
        bus_start();
        send_byte(8'hE8, 1'b0, "R2 no ack");
        send_byte(8'h55, 1'b0, "R2 byte ignored");
        bus_stop();
        chk("R2 no write", we_count - we_base, 0);

        // R1: strap pin changes the address to 7'h74
        strap = 1'b0;
        wait_n(Q);
        expect_wr(8'h20, 8'h3C);
        bus_start();
        send_byte(8'hE8, 1'b1, "R1 new address ack");
        send_byte(8'h20, 1'b1, "R3 pointer ack");
        send_byte(8'h3C, 1'b1, "R3 data ack");
        bus_stop();
        bus_start();
        send_byte(8'hEA, 1'b0, "R1 old address no ack");
        bus_stop();
        chk("R1 strap write drained", exp_wr.size(), 0);

        // R7: general call
        exp_gc.push_back(8'h06);
        bus_start();
        send_byte(8'h00, 1'b1, "R7 general call ack");
        send_byte(8'h06, 1'b1, "R7 command ack");
        send_byte(8'h99, 1'b0, "R7 later byte ignored");
        bus_stop();
        bus_start();
        send_byte(8'h01, 1'b0, "R7 general call read no ack");
        bus_stop();
        chk("R7 gc drained", exp_gc.size(), 0);

        // R9: empty message, then a normal transfer
        we_base = we_count;
        re_base = re_count;
        sda_m = 1'b0;
        wait_n(Q);
        sda_m = 1'b1;
        wait_n(2 * Q);
        chk("R9 no write", we_count - we_base, 0);
        chk("R9 no read", re_count - re_base, 0);
        expect_wr(8'h30, 8'h77);
        bus_start();
        send_byte(8'hE8, 1'b1, "R9 address ack after empty message");
        send_byte(8'h30, 1'b1, "R9 pointer ack");
        send_byte(8'h77, 1'b1, "R9 data ack");
        bus_stop();
        chk("R9 write drained", exp_wr.size(), 0);

        // R8: repeated START in the middle of a byte
        expect_wr(8'h40, 8'h12);
        bus_start();
        send_byte(8'hE8, 1'b1, "R8 address ack");
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        bus_start();
        send_byte(8'hE8, 1'b1, "R8 address after restart");
        send_byte(8'h40, 1'b1, "R8 pointer ack");
        send_byte(8'h12, 1'b1, "R8 data ack");
        bus_stop();
        chk("R8 write drained", exp_wr.size(), 0);

        // R4: pointer wrap on write and on read
        expect_wr(8'hFF, 8'hAB);
        expect_wr(8'h00, 8'hCD);
        bus_start();
        send_byte(8'hE8, 1'b1, "R4 address ack");
        send_byte(8'hFF, 1'b1, "R4 pointer ack");
        send_byte(8'hAB, 1'b1, "R4 data ack");
        send_byte(8'hCD, 1'b1, "R4 data ack");
        bus_start();
        send_byte(8'hE8, 1'b1, "R4 address ack");
        send_byte(8'hFF, 1'b1, "R4 pointer ack");
        bus_start();
        send_byte(8'hE9, 1'b1, "R4 read address ack");
        recv_byte(1'b1, ref_mem[8'hFF], "R4 read at FF");
        recv_byte(1'b0, ref_mem[8'h00], "R4 read wraps to 00");
        bus_stop();
        chk("R4 wrap drained", exp_wr.size(), 0);

        wait_n(Q);
        chk("R10 sda_oe stable while SCL high", r10_bad, 0);
        chk("R11 strobe shape", r11_bad, 0);
        finish_run();
    end

endmodule